// File: doc/BRIEF.md
# Memory-to-Memory Processor Arithmetic/Logic Unit

This block computes the value a small memory-to-memory processor writes back to its destination word. It is purely combinational. The controller presents a 3-bit operation code, the current contents of the destination word as the first operand, and a second operand. The second operand is either another memory word or a 14-bit literal that the controller has already zero-extended. The block returns one 32-bit result in the same cycle. It raises no flags, keeps no carry and treats every value as unsigned.

The operations are wrap-around addition, the low half of a multiplication, bitwise NAND, an unsigned set-on-less-than and a pass-through of the second operand for the copy-style instructions. There is also a two-way shift. The shift amount comes from the second operand and also sets the direction: amounts below the word width shift right, amounts from one to two word widths shift left by the excess, and anything larger clears the word.

Top module: `alu_custom`

## Requirements
- R1: With op_i = 0, res_o equals x_i + y_i truncated to 32 bits, with no overflow indication.
- R2: With op_i = 7, res_o equals the low 32 bits of the unsigned product x_i * y_i.
- R3: With op_i = 1, res_o equals the bitwise NAND of x_i and y_i.
- R4: With op_i = 2 and y_i below 32, res_o is x_i shifted right by y_i, with zeros filling from the top.
- R5: With op_i = 2 and y_i from 32 to 63, res_o is x_i shifted left by y_i - 32, with zeros filling from the bottom.
- R6: With op_i = 2 and y_i of 64 or more, res_o is zero.
- R7: With op_i = 3, res_o is 1 when x_i < y_i as unsigned numbers and 0 otherwise. Bits 31 to 1 are always zero.
- R8: With op_i = 4, 5 or 6, res_o equals y_i, and x_i has no effect.
- R9: res_o follows a change on any input within the same cycle, with no register between the inputs and the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code (0 add, 1 NAND, 2 shift, 3 less-than, 4/5/6 pass, 7 multiply) |
| x_i | input | 32 | First operand, the destination's current value |
| y_i | input | 32 | Second operand, a memory word or a zero-extended literal |
| res_o | output | 32 | Result to be written back |

## Verification
The checker assumes that every input carries a known two-state value whenever it is evaluated. It also assumes that all eight opcodes are legal, so no code is excluded. The stimulus drives only fully defined values and changes them once per cycle, away from the instant the results are sampled. Shift amounts are drawn from three separate bands (right, left, cleared) and the band edges are driven directly, so every shift path is reached. The second operand's full 32-bit range is used as well as small literal-sized values.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned ALU_W = 32;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_NAND  = 3'd1,
    OP_SHIFT = 3'd2,
    OP_SLT   = 3'd3,
    OP_COPY  = 3'd4,
    OP_IND   = 3'd5,
    OP_BR    = 3'd6,
    OP_MUL   = 3'd7
  } alu_op_e;

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] prod_o
);

  // Wrap-around add: carry out is dropped.
  function automatic logic [W-1:0] add_wrap(input logic [W-1:0] a, input logic [W-1:0] b);
    return a + b;
  endfunction

  // Low half of the full product.
  function automatic logic [W-1:0] mul_low(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] full;
    full = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    return full[W-1:0];
  endfunction

  assign sum_o  = add_wrap(a_i, b_i);
  assign prod_o = mul_low(a_i, b_i);

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] nand_o,
  output logic [W-1:0] slt_o
);

  function automatic logic [W-1:0] bit_nand(input logic [W-1:0] a, input logic [W-1:0] b);
    return ~(a & b);
  endfunction

  function automatic logic [W-1:0] set_below(input logic [W-1:0] a, input logic [W-1:0] b);
    return {{(W-1){1'b0}}, (a < b)};
  endfunction

  assign nand_o = bit_nand(a_i, b_i);
  assign slt_o  = set_below(a_i, b_i);

endmodule

// File: rtl/alu_barrel.sv
module alu_barrel #(
  parameter int unsigned W    = 32,
  parameter bit          LEFT = 1'b0,
  localparam int unsigned SW  = $clog2(W)
) (
  input  logic [W-1:0]  d_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  q_o
);

  logic [W-1:0] stg [0:SW];

  assign stg[0] = d_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    if (LEFT) begin : g_l
      assign stg[k+1] = amt_i[k] ? (stg[k] << (1 << k)) : stg[k];
    end else begin : g_r
      assign stg[k+1] = amt_i[k] ? (stg[k] >> (1 << k)) : stg[k];
    end
  end

  assign q_o = stg[SW];

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int unsigned W   = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] res_o,
  output logic         left_o,
  output logic         kill_o
);

  // Band limits: below W shift right, below 2W shift left, else clear.
  localparam logic [W-1:0] LIM_R = W'(W);
  localparam logic [W-1:0] LIM_L = W'(2 * W);

  logic [W-1:0] rsh;
  logic [W-1:0] lsh;

  // W is a power of two, so y - W and y agree in the low SW bits.
  alu_barrel #(.W(W), .LEFT(1'b0)) u_right (
    .d_i  (x_i),
    .amt_i(y_i[SW-1:0]),
    .q_o  (rsh)
  );

  alu_barrel #(.W(W), .LEFT(1'b1)) u_left (
    .d_i  (x_i),
    .amt_i(y_i[SW-1:0]),
    .q_o  (lsh)
  );

  assign kill_o = (y_i >= LIM_L);
  assign left_o = (y_i >= LIM_R) && !kill_o;

  always_comb begin
    if (kill_o)      res_o = '0;
    else if (left_o) res_o = lsh;
    else             res_o = rsh;
  end

endmodule

// File: rtl/alu_custom.sv
module alu_custom #(
  parameter int unsigned W = alu_pkg::ALU_W
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] res_o
);
  import alu_pkg::*;

  alu_op_e      op;
  logic [W-1:0] sum_w;
  logic [W-1:0] prod_w;
  logic [W-1:0] nand_w;
  logic [W-1:0] slt_w;
  logic [W-1:0] shift_w;
  logic         shift_left_w;
  logic         shift_kill_w;

  assign op = alu_op_e'(op_i);

  alu_arith #(.W(W)) u_arith (
    .a_i   (x_i),
    .b_i   (y_i),
    .sum_o (sum_w),
    .prod_o(prod_w)
  );

  alu_logic #(.W(W)) u_logic (
    .a_i   (x_i),
    .b_i   (y_i),
    .nand_o(nand_w),
    .slt_o (slt_w)
  );

  alu_shift #(.W(W)) u_shift (
    .x_i   (x_i),
    .y_i   (y_i),
    .res_o (shift_w),
    .left_o(shift_left_w),
    .kill_o(shift_kill_w)
  );

  always_comb begin
    unique case (op)
      OP_ADD:   res_o = sum_w;
      OP_NAND:  res_o = nand_w;
      OP_SHIFT: res_o = shift_w;
      OP_SLT:   res_o = slt_w;
      OP_MUL:   res_o = prod_w;
      default:  res_o = y_i;
    endcase
  end

endmodule

// File: rtl/alu_custom_chk.sv
module alu_custom_chk #(
  parameter int unsigned W = 32
) (
  input logic [2:0]   op_i,
  input logic [W-1:0] x_i,
  input logic [W-1:0] y_i,
  input logic [W-1:0] res_o,
  input logic         shift_left_w,
  input logic         shift_kill_w
);

  localparam logic [W-1:0] LIM_R = W'(W);
  localparam logic [W-1:0] LIM_L = W'(2 * W);

  logic [W-1:0] low_mask;
  assign low_mask = ({{(W-1){1'b0}}, 1'b1} << (y_i - LIM_R)) - 1'b1;

  always_comb begin
    if (!$isunknown({op_i, x_i, y_i})) begin
      // R1
      add_wrap_chk: assert (op_i != 3'd0 || (res_o - y_i) == x_i)
        else $error("add_wrap_chk");
      // R2
      mul_unit_chk: assert (op_i != 3'd7 || y_i > 1 || res_o == (y_i == 0 ? '0 : x_i))
        else $error("mul_unit_chk");
      // R3
      nand_bits_chk: assert (op_i != 3'd1 || (((res_o & x_i & y_i) == '0) && ((res_o | (x_i & y_i)) == '1)))
        else $error("nand_bits_chk");
      // R4
      shr_shrink_chk: assert (op_i != 3'd2 || y_i >= LIM_R || (res_o <= x_i && !shift_left_w && !shift_kill_w))
        else $error("shr_shrink_chk");
      // R5
      shl_lowzero_chk: assert (op_i != 3'd2 || y_i < LIM_R || y_i >= LIM_L || ((res_o & low_mask) == '0 && shift_left_w))
        else $error("shl_lowzero_chk");
      // R6
      shift_clear_chk: assert (op_i != 3'd2 || y_i < LIM_L || (res_o == '0 && shift_kill_w))
        else $error("shift_clear_chk");
      // R7
      slt_range_chk: assert (op_i != 3'd3 || (res_o[W-1:1] == '0 && (x_i != y_i || res_o == '0)))
        else $error("slt_range_chk");
      // R8
      copy_pass_chk: assert (!(op_i inside {3'd4, 3'd5, 3'd6}) || res_o == y_i)
        else $error("copy_pass_chk");
    end
  end

endmodule

bind alu_custom alu_custom_chk #(.W(W)) u_alu_custom_chk (
  .op_i        (op_i),
  .x_i         (x_i),
  .y_i         (y_i),
  .res_o       (res_o),
  .shift_left_w(shift_left_w),
  .shift_kill_w(shift_kill_w)
);

// File: tb/test_alu_custom.sv
module test_alu_custom;

  localparam int unsigned W = 32;

  typedef struct {
    logic [2:0]   op;
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic [W-1:0] exp;
    string        req;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   op = '0;
  logic [W-1:0] x = '0;
  logic [W-1:0] y = '0;
  logic [W-1:0] res;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  alu_custom #(.W(W)) i_alu_custom (
    .op_i (op),
    .x_i  (x),
    .y_i  (y),
    .res_o(res)
  );

  // Independent behavioural model.
  function automatic logic [W-1:0] model(input logic [2:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [63:0] wide;
    logic [W-1:0] r;
    case (o)
      3'd0: begin wide = {32'b0, a} + {32'b0, b}; return wide[W-1:0]; end
      3'd7: begin wide = {32'b0, a} * {32'b0, b}; return wide[W-1:0]; end
      3'd1: return (~a) | (~b);
      3'd2: begin
        r = a;
        if (b < 32) begin
          for (int i = 0; i < int'(b); i++) r = r / 2;
        end else if (b < 64) begin
          for (int i = 0; i < int'(b) - 32; i++) r = r * 2;
        end else begin
          r = '0;
        end
        return r;
      end
      3'd3: return (a < b) ? 32'd1 : 32'd0;
      default: return b;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] o, input logic [W-1:0] b);
    case (o)
      3'd0: return "R1";
      3'd7: return "R2";
      3'd1: return "R3";
      3'd2: return (b < 32) ? "R4" : (b < 64) ? "R5" : "R6";
      3'd3: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(input logic [2:0] o, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    item_t it;
    @(posedge clk);
    op = o; x = a; y = b;
    it.op = o; it.x = a; it.y = b; it.exp = model(o, a, b);
    it.req = (tag == "") ? req_of(o, b) : tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares half a cycle after each drive (R9: same-cycle response).
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (res !== it.exp) begin
        fails++;
        $display("FAIL %s op=%0d x=%h y=%h actual=%h expected=%h", it.req, it.op, it.x, it.y, res, it.exp);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // Reset-time state: all-zero inputs give a zero sum (R1).
    repeat (2) @(posedge clk);
    #1;
    checks++;
    if (res !== '0) begin
      fails++;
      $display("FAIL R1 reset actual=%h expected=%h", res, 32'h0);
    end
    rst_n = 1'b1;

    // R1 wrap-around
    drive(3'd0, 32'hFFFF_FFFF, 32'h1, "R1");
    drive(3'd0, 32'h1234_5678, 32'h0000_3FFF, "R1");
    // R2 low product
    drive(3'd7, 32'h0001_0000, 32'h0001_0000, "R2");
    drive(3'd7, 32'hFFFF_FFFF, 32'h3, "R2");
    // R3 NAND
    drive(3'd1, 32'hF0F0_F0F0, 32'hFF00_FF00, "R3");
    // R4 right shift, zero fill
    drive(3'd2, 32'h8000_0001, 32'd0, "R4");
    drive(3'd2, 32'h8000_0000, 32'd31, "R4");
    // R5 left shift by amount minus 32
    drive(3'd2, 32'h0000_0003, 32'd32, "R5");
    drive(3'd2, 32'h0000_0003, 32'd63, "R5");
    // R6 cleared
    drive(3'd2, 32'hFFFF_FFFF, 32'd64, "R6");
    drive(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
    // R7 less-than edges
    drive(3'd3, 32'd5, 32'd5, "R7");
    drive(3'd3, 32'd4, 32'd5, "R7");
    drive(3'd3, 32'hFFFF_FFFF, 32'h0, "R7");
    // R8 pass-through ignores x
    drive(3'd4, 32'hDEAD_BEEF, 32'h0000_1234, "R8");
    drive(3'd5, 32'h0, 32'hCAFE_0001, "R8");
    drive(3'd6, 32'hFFFF_FFFF, 32'h0, "R8");
    // R9 back-to-back changes every cycle
    for (int i = 0; i < 2000; i++) begin
      logic [2:0]   o;
      logic [W-1:0] a;
      logic [W-1:0] b;
      o = 3'($urandom_range(0, 7));
      a = $urandom();
      case ($urandom_range(0, 3))
        0: b = 32'($urandom_range(0, 31));
        1: b = 32'($urandom_range(32, 63));
        2: b = 32'($urandom_range(0, 16383));
        default: b = $urandom();
      endcase
      drive(o, a, b, (i % 2 == 0) ? "R9" : "");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule